// File: doc/BRIEF.md
# Bus Port Fence Sequencer

This block isolates a group of bus ports from the interconnect, or reconnects them, before and after a power-domain change. A request carries a direction and a port mask. The block then drives two internal enable vectors in a fixed order. The first is the fence enable and the second is a clock-gate enable. Each is changed only through a set path and a clear path, so bits outside the mask keep their value. When fencing, the block also waits until the interconnect reports every masked port as quiet.

A keyed unlock word guards all of this. Requests are taken only while the last word written to it carried the correct key and its enable bit. A bad write locks the block again. Each sequence ends with a one-cycle completion pulse or a one-cycle time-out pulse.

Top module: `bus_fence_ctrl`

## Requirements
- R1: After reset the block is locked, and `fence_en`, `clkgate_en`, `busy`, `done` and `timeout` are all 0. Writing the unlock word with 0x0B16 in bits 31:16 and bit 0 at 1 unlocks it. Any other written value locks it.
- R2: While locked, a request is ignored. `busy` stays 0, and `fence_en` and `clkgate_en` do not change.
- R3: On the first clock edge after a request is accepted, `clkgate_en` gains the masked bits. Every other bit of both vectors is unchanged.
- R4: In fence mode (`req_fence`=1), `fence_en` gains the masked bits on the second edge after acceptance. All other bits are unchanged.
- R5: In release mode (`req_fence`=0), `fence_en` loses the masked bits on the second edge. There is no wait for status. On the third edge the masked `clkgate_en` bits clear and `done` pulses.
- R6: In fence mode the block waits until every masked bit of `port_idle` reads 1. The check uses a two-flop synchronized copy, and unmasked bits of `port_idle` are ignored. A bit that goes high before edge d (counted from the accepting edge, d≥1) takes effect at edge d+2. The first edge at which the match is checked is edge 3.
- R7: When a fence match is found at edge n, the masked `clkgate_en` bits clear and `done` pulses at edge n+1. With an all-zero mask, `done` comes at edge 4.
- R8: If there is no match at any of the TIMEOUT_CYC wait edges (edges 3 through TIMEOUT_CYC+2), `timeout` pulses after edge TIMEOUT_CYC+2. In that case `fence_en` and the masked `clkgate_en` bits stay set.
- R9: A match seen at the last wait edge (edge TIMEOUT_CYC+2) wins over the time-out.
- R10: `done` and `timeout` are single-cycle pulses and are never high together. `busy` is 1 from the accepting edge until the pulse. Requests made while busy are ignored. The mask and mode are captured at acceptance, so later changes on `req_mask` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| unlock_we | input | 1 | Write strobe for the unlock word |
| unlock_wdata | input | 32 | Unlock word: key in bits 31:16, enable in bit 0 |
| req_valid | input | 1 | Request strobe, taken when idle and unlocked |
| req_fence | input | 1 | 1 = fence ports, 0 = release ports |
| req_mask | input | NPORT | Ports affected by the request |
| port_idle | input | NPORT | Asynchronous per-port quiet status from the interconnect |
| fence_en | output | NPORT | Fence enable vector |
| clkgate_en | output | NPORT | Clock-gate enable vector |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | One-cycle time-out pulse |

## Verification
The critical collision is the status match arriving on the very wait cycle where the time-out counter expires. In that cycle the completion path and the time-out path both qualify. The bench sweeps the arrival of `port_idle` across every delay around the limit: one before the limit, exactly at it, and one past it. It checks which of `done` or `timeout` pulses, and on which edge, against the edge computed from the synchronizer depth. A second overlap is a fresh request arriving while a sequence is running. This is provoked mid-sequence with a different mode and mask, and judged from the vectors left behind.

// File: rtl/bfc_pkg.sv
package bfc_pkg;

    localparam logic [15:0] UNLOCK_KEY = 16'h0B16;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_CG_ON,
        SQ_FENCE,
        SQ_WAIT,
        SQ_CG_OFF
    } seq_state_e;

    function automatic logic key_ok(input logic [31:0] word);
        return (word[31:16] == UNLOCK_KEY) && word[0];
    endfunction

endpackage

// File: rtl/bfc_sync2.sv
module bfc_sync2 #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/bfc_w1sc_reg.sv
module bfc_w1sc_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_bits,
    input  logic [W-1:0] clr_bits,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= (q | set_bits) & ~clr_bits;
    end
endmodule

// File: rtl/bfc_unlock.sv
module bfc_unlock (
    input  logic        clk,
    input  logic        rst,
    input  logic        we,
    input  logic [31:0] wdata,
    output logic        unlocked
);
    import bfc_pkg::*;

    always_ff @(posedge clk) begin
        if (rst)     unlocked <= 1'b0;
        else if (we) unlocked <= key_ok(wdata);
    end
endmodule

// File: rtl/bfc_seq.sv
module bfc_seq #(
    parameter int NPORT       = 8,
    parameter int TIMEOUT_CYC = 500
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             fence_mode,
    input  logic [NPORT-1:0] mask,
    input  logic [NPORT-1:0] idle_sync,
    output logic [NPORT-1:0] cg_set,
    output logic [NPORT-1:0] cg_clr,
    output logic [NPORT-1:0] en_set,
    output logic [NPORT-1:0] en_clr,
    output logic [NPORT-1:0] mask_q,
    output logic             busy,
    output logic             done,
    output logic             timeout
);
    import bfc_pkg::*;

    localparam int CW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

    seq_state_e state;
    logic       mode_q;
    logic [CW-1:0] cnt;
    logic       matched;

    assign matched = (idle_sync & mask_q) == mask_q;
    assign busy    = (state != SQ_IDLE);

    always_comb begin
        cg_set = '0;
        cg_clr = '0;
        en_set = '0;
        en_clr = '0;
        case (state)
            SQ_CG_ON:  cg_set = mask_q;
            SQ_FENCE:  if (mode_q) en_set = mask_q; else en_clr = mask_q;
            SQ_CG_OFF: cg_clr = mask_q;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SQ_IDLE;
            mask_q  <= '0;
            mode_q  <= 1'b0;
            cnt     <= '0;
            done    <= 1'b0;
            timeout <= 1'b0;
        end else begin
            done    <= 1'b0;
            timeout <= 1'b0;
            case (state)
                SQ_IDLE: if (start) begin
                    mask_q <= mask;
                    mode_q <= fence_mode;
                    state  <= SQ_CG_ON;
                end
                SQ_CG_ON: state <= SQ_FENCE;
                SQ_FENCE: begin
                    cnt   <= '0;
                    state <= mode_q ? SQ_WAIT : SQ_CG_OFF;
                end
                SQ_WAIT: begin
                    if (matched) begin
                        state <= SQ_CG_OFF;
                    end else if (cnt == LAST) begin
                        timeout <= 1'b1;
                        state   <= SQ_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SQ_CG_OFF: begin
                    done  <= 1'b1;
                    state <= SQ_IDLE;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bus_fence_ctrl.sv
module bus_fence_ctrl #(
    parameter int NPORT       = 8,
    parameter int TIMEOUT_CYC = 500
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             unlock_we,
    input  logic [31:0]      unlock_wdata,
    input  logic             req_valid,
    input  logic             req_fence,
    input  logic [NPORT-1:0] req_mask,
    input  logic [NPORT-1:0] port_idle,
    output logic [NPORT-1:0] fence_en,
    output logic [NPORT-1:0] clkgate_en,
    output logic             busy,
    output logic             done,
    output logic             timeout
);
    logic             unlocked;
    logic             start;
    logic [NPORT-1:0] idle_sync;
    logic [NPORT-1:0] cg_set, cg_clr, en_set, en_clr, mask_q;

    bfc_unlock u_unlock (
        .clk(clk), .rst(rst), .we(unlock_we), .wdata(unlock_wdata),
        .unlocked(unlocked)
    );

    bfc_sync2 #(.W(NPORT)) u_sync (
        .clk(clk), .rst(rst), .d(port_idle), .q(idle_sync)
    );

    assign start = req_valid && unlocked && !busy;

    bfc_seq #(.NPORT(NPORT), .TIMEOUT_CYC(TIMEOUT_CYC)) u_seq (
        .clk(clk), .rst(rst), .start(start), .fence_mode(req_fence),
        .mask(req_mask), .idle_sync(idle_sync),
        .cg_set(cg_set), .cg_clr(cg_clr), .en_set(en_set), .en_clr(en_clr),
        .mask_q(mask_q), .busy(busy), .done(done), .timeout(timeout)
    );

    bfc_w1sc_reg #(.W(NPORT)) u_fence_reg (
        .clk(clk), .rst(rst), .set_bits(en_set), .clr_bits(en_clr),
        .q(fence_en)
    );

    bfc_w1sc_reg #(.W(NPORT)) u_cg_reg (
        .clk(clk), .rst(rst), .set_bits(cg_set), .clr_bits(cg_clr),
        .q(clkgate_en)
    );
endmodule

// File: rtl/bus_fence_ctrl_chk.sv
module bus_fence_ctrl_chk #(
    parameter int NPORT = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             done,
    input logic             timeout,
    input logic             unlocked,
    input logic             req_valid,
    input logic [NPORT-1:0] fence_en,
    input logic [NPORT-1:0] clkgate_en,
    input logic [NPORT-1:0] mask_q
);
    // R10: pulses are exclusive and last one cycle
    p_pulse_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(done && timeout));
    p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R2: a locked idle block stays idle
    p_locked_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (!unlocked && !busy) |=> !busy);
    // R3/R4: vectors only move while a sequence runs
    p_fence_moves_busy_r4: assert property (@(posedge clk) disable iff (rst)
        (fence_en != $past(fence_en)) |-> $past(busy));
    p_cg_moves_busy_r3: assert property (@(posedge clk) disable iff (rst)
        (clkgate_en != $past(clkgate_en)) |-> $past(busy));
    // R7: completion leaves masked clock-gate bits clear
    p_done_cg_clear_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> ((clkgate_en & mask_q) == '0));
    // R8: time-out leaves masked bits set
    p_timeout_keeps_r8: assert property (@(posedge clk) disable iff (rst)
        timeout |-> ((clkgate_en & mask_q) == mask_q && (fence_en & mask_q) == mask_q));
    // R10: no pulse while idle-request path unused
    p_busy_ends_r10: assert property (@(posedge clk) disable iff (rst)
        (done || timeout) |-> !busy);
endmodule

bind bus_fence_ctrl bus_fence_ctrl_chk #(.NPORT(NPORT)) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .done(done), .timeout(timeout),
    .unlocked(unlocked), .req_valid(req_valid), .fence_en(fence_en),
    .clkgate_en(clkgate_en), .mask_q(mask_q)
);

// File: tb/bus_fence_ctrl_test.sv
module bus_fence_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;
    localparam int TO = 12;

    logic          clk = 1'b0;
    logic          rst;
    logic          unlock_we;
    logic [31:0]   unlock_wdata;
    logic          req_valid;
    logic          req_fence;
    logic [NP-1:0] req_mask;
    logic [NP-1:0] port_idle;
    logic [NP-1:0] fence_en, clkgate_en;
    logic          busy, done, timeout;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [NP-1:0] fence_m, cg_m;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_fence_ctrl #(.NPORT(NP), .TIMEOUT_CYC(TO)) uut (
        .clk(clk), .rst(rst), .unlock_we(unlock_we), .unlock_wdata(unlock_wdata),
        .req_valid(req_valid), .req_fence(req_fence), .req_mask(req_mask),
        .port_idle(port_idle), .fence_en(fence_en), .clkgate_en(clkgate_en),
        .busy(busy), .done(done), .timeout(timeout)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic write_unlock(input logic [31:0] w);
        @(negedge clk);
        unlock_we = 1'b1; unlock_wdata = w;
        @(negedge clk);
        unlock_we = 1'b0;
    endtask

    // Request while locked: nothing may change (R2)
    task automatic locked_try(input logic [NP-1:0] m);
        @(negedge clk);
        req_valid = 1'b1; req_fence = 1'b1; req_mask = m;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk(busy == 1'b0, "R2 busy", busy, 0);
        end
        chk(fence_en == fence_m, "R2 fence_en", fence_en, fence_m);
        chk(clkgate_en == cg_m, "R2 clkgate_en", clkgate_en, cg_m);
    endtask

    // d: edge before which masked idle bits rise (0 = never)
    task automatic run_seq(input logic fmode, input logic [NP-1:0] m, input int d);
        int de, te;
        logic [NP-1:0] cg_mid, fence_new;
        if (!fmode) begin de = 3; te = -1; end
        else if (m == '0) begin de = 4; te = -1; end
        else if (d >= 1 && d <= TO) begin de = ((d + 2 > 3) ? d + 2 : 3) + 1; te = -1; end
        else begin de = -1; te = TO + 2; end
        cg_mid    = cg_m | m;
        fence_new = fmode ? (fence_m | m) : (fence_m & ~m);
        @(negedge clk);
        req_valid = 1'b1; req_fence = fmode; req_mask = m;
        port_idle = ~m;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (d == 1) port_idle = '1;
        for (int k = 1; k <= TO + 5; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (k == 1) begin
                chk(busy == 1'b1, "R10 busy after accept", busy, 1);
                chk(clkgate_en == cg_mid, "R3 clkgate set", clkgate_en, cg_mid);
                chk(fence_en == fence_m, "R3 fence untouched", fence_en, fence_m);
                req_mask = '1;
            end
            if (k == 2) begin
                chk(fence_en == fence_new, fmode ? "R4 fence set" : "R5 fence clear",
                    fence_en, fence_new);
                req_valid = 1'b1; req_fence = ~fmode; req_mask = ~m;
            end
            if (k == 3) req_valid = 1'b0;
            chk(done == (k == de), fmode ? "R7 done timing" : "R5 done timing", done, (k == de));
            chk(timeout == (k == te), (te == TO + 2) ? "R8 timeout timing" : "R9 no timeout",
                timeout, (k == te));
            if (k == de)
                chk((clkgate_en & m) == '0, "R7 clkgate cleared", clkgate_en, cg_mid & ~m);
            if (k == te)
                chk((clkgate_en & m) == m, "R8 clkgate kept", clkgate_en, cg_mid);
            if ((k == de) || (k == te))
                chk(busy == 1'b0, "R10 busy ends", busy, 0);
            if (k == d - 1 && fmode) port_idle = '1;
        end
        chk(fence_en == fence_new, "R10 ignored busy request", fence_en, fence_new);
        fence_m = fence_new;
        cg_m    = (te > 0) ? cg_mid : (cg_mid & ~m);
        chk(clkgate_en == cg_m, "R6 clkgate final", clkgate_en, cg_m);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                $display("FAIL watchdog expired");
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        rst = 1'b1; unlock_we = 1'b0; unlock_wdata = '0;
        req_valid = 1'b0; req_fence = 1'b0; req_mask = '0; port_idle = '0;
        fence_m = '0; cg_m = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(fence_en == '0 && clkgate_en == '0, "R1 reset vectors", {fence_en, clkgate_en}, 0);
        chk(!busy && !done && !timeout, "R1 reset flags", {busy, done, timeout}, 0);

        locked_try(4'b0101);
        write_unlock(32'h0B17_0001);
        locked_try(4'b0011);
        write_unlock(32'h0B16_0000);
        locked_try(4'b1000);
        write_unlock(32'h0B16_0001);

        // R5: release sweep over all masks on an all-fenced state
        for (int m = 0; m < 16; m++) begin
            run_seq(1'b1, 4'hF, 1);
            run_seq(1'b0, NP'(m), 0);
        end
        // R6 R8 R9: fence sweep over masks and idle arrival delays
        for (int m = 0; m < 16; m++) begin
            for (int j = 0; j < 7; j++) begin
                int dd;
                case (j)
                    0: dd = 1;
                    1: dd = 2;
                    2: dd = 5;
                    3: dd = TO - 1;
                    4: dd = TO;
                    5: dd = TO + 1;
                    default: dd = 0;
                endcase
                run_seq(1'b0, 4'hF, 0);
                run_seq(1'b1, NP'(m), dd);
            end
        end

        write_unlock(32'h0000_0001);
        locked_try(4'b1111);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule